// File: doc/BRIEF.md
# Alarm Status and Interrupt Register

This block gathers two kinds of receive-side indications into two readable status words and drives one interrupt line. Nine one-cycle error pulses come in: parity errors for the section, line and path overheads, block-error counter overflows and code-violation counter overflows. Each pulse sets a sticky bit, and the bit clears when its word is read. Four level alarms come in as well: loss of cell alignment, loss of signal, out of frame and loss of frame. Each alarm bit follows its condition one cycle late, and reading does not clear it.

The interrupt rises on any error event and on any change of an alarm bit, in either direction. Any status read drops it. A new event in the same cycle as a read wins over the read. A controller reads a word by pulsing `rd_en` with `rd_sel` set; the word appears on `rd_data` after the next clock edge. Either a hardware or a software reset returns the block to its initial state.

Top module: `als_status_top`

## Requirements
- R1: A pulse on `err_evt[i]` sets error bit i and makes `intr` high after that clock edge. Bit order: 0 section parity, 1 line parity, 2 path parity, 3..5 block-error overflow (section, line, path), 6..8 code-violation overflow (section, line, path).
- R2: An error bit stays set over cycles with no read and over reads of the alarm word (`rd_sel`=1).
- R3: A read with `rd_sel`=0 puts the error word on `rd_data[8:0]`, zero above, after the strobe's edge. The same read clears the error bits.
- R4: An error event in the same cycle as an error-word read leaves its bit set and leaves `intr` high. The returned data is the word as it stood before that edge.
- R5: The alarm bits take the value of `alm_lvl` one cycle later. A read with `rd_sel`=1 returns them on `rd_data[3:0]` (0 cell alignment loss, 1 signal loss, 2 out of frame, 3 frame loss). Reading leaves them unchanged.
- R6: A rising or falling change of any alarm bit makes `intr` high.
- R7: A read of either word drives `intr` low after its edge when no error event or alarm change occurs in that cycle.
- R8: An alarm change in the same cycle as a read keeps `intr` high.
- R9: `rst` or `sw_rst` clears the error bits, `intr` and `rd_data`. It loads the alarm bits with 4'b1101: cell alignment loss, out of frame and frame loss set; signal loss clear.
- R10: With no event, no alarm change and no read, `intr` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Hardware reset, synchronous, active high |
| sw_rst | input | 1 | Software reset, synchronous, active high |
| err_evt | input | 9 | One-cycle error event pulses |
| alm_lvl | input | 4 | Alarm condition levels |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | Word select: 0 error word, 1 alarm word |
| rd_data | output | 16 | Read data, valid after the strobe's edge |
| intr | output | 1 | Interrupt, registered, active high |

## Verification
All results of this block land at the clock edge that samples their stimulus: the error bits, the alarm copy, `intr` and `rd_data` each sit one register deep. The bench therefore drives each stimulus on the falling edge. It then waits for the next rising edge and samples one nanosecond later. Read data is compared in the same row as its strobe. Same-edge races get their own rows: an event during an error read, and an alarm change during a read.

// File: rtl/als_pkg.sv
package als_pkg;

    localparam int NUM_ERR = 9;
    localparam int NUM_ALM = 4;
    localparam int DATA_W  = 16;

    // reset image of the alarm word: cell alignment loss, out of frame, frame loss set
    localparam logic [NUM_ALM-1:0] ALM_RST = 4'b1101;

    typedef enum logic {
        SEL_ERR = 1'b0,
        SEL_ALM = 1'b1
    } word_sel_e;

    typedef struct packed {
        logic      en;
        word_sel_e sel;
    } rd_req_t;

    function automatic logic [DATA_W-1:0] pad_err(input logic [NUM_ERR-1:0] v);
        logic [DATA_W-1:0] r;
        r = '0;
        r[NUM_ERR-1:0] = v;
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] pad_alm(input logic [NUM_ALM-1:0] v);
        logic [DATA_W-1:0] r;
        r = '0;
        r[NUM_ALM-1:0] = v;
        return r;
    endfunction

endpackage

// File: rtl/als_err_bank.sv
module als_err_bank #(
    parameter int N = 9
) (
    input  logic         clk,
    input  logic         rst_any,
    input  logic [N-1:0] evt,
    input  logic         clr,
    output logic [N-1:0] q
);
    // one sticky flop per event source; a fresh event outranks the clear
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst_any) q[i] <= 1'b0;
            else         q[i] <= (q[i] & ~clr) | evt[i];
        end
    end
endmodule

// File: rtl/als_alm_track.sv
module als_alm_track #(
    parameter int             N   = 4,
    parameter logic [N-1:0]   RST = '1
) (
    input  logic         clk,
    input  logic         rst_any,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] q,
    output logic         chg
);
    always_ff @(posedge clk) begin
        if (rst_any) q <= RST;
        else         q <= lvl;
    end

    // a bit that differs from its registered copy changes at the coming edge
    assign chg = |(lvl ^ q);
endmodule

// File: rtl/als_intr_gen.sv
module als_intr_gen (
    input  logic clk,
    input  logic rst_any,
    input  logic set,
    input  logic rd,
    output logic intr
);
    always_ff @(posedge clk) begin
        if (rst_any)  intr <= 1'b0;
        else if (set) intr <= 1'b1;
        else if (rd)  intr <= 1'b0;
    end
endmodule

// File: rtl/als_rd_port.sv
module als_rd_port
    import als_pkg::*;
#(
    parameter int NE = NUM_ERR,
    parameter int NA = NUM_ALM,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_any,
    input  rd_req_t       req,
    input  logic [NE-1:0] err_q,
    input  logic [NA-1:0] alm_q,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] word;

    always_comb begin
        word = '0;
        if (req.sel == SEL_ALM) word[NA-1:0] = alm_q;
        else                    word[NE-1:0] = err_q;
    end

    always_ff @(posedge clk) begin
        if (rst_any)     rd_data <= '0;
        else if (req.en) rd_data <= word;
    end
endmodule

// File: rtl/als_status_top.sv
module als_status_top
    import als_pkg::*;
#(
    parameter int                NE  = NUM_ERR,
    parameter int                NA  = NUM_ALM,
    parameter int                DW  = DATA_W,
    parameter logic [NA-1:0]     ARV = ALM_RST
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sw_rst,
    input  logic [NE-1:0] err_evt,
    input  logic [NA-1:0] alm_lvl,
    input  logic          rd_en,
    input  logic          rd_sel,
    output logic [DW-1:0] rd_data,
    output logic          intr
);
    logic          rst_any;
    rd_req_t       req;
    logic [NE-1:0] err_q;
    logic [NA-1:0] alm_q;
    logic          alm_chg;
    logic          err_clr;

    assign rst_any = rst | sw_rst;
    assign req.en  = rd_en;
    assign req.sel = word_sel_e'(rd_sel);
    assign err_clr = req.en && (req.sel == SEL_ERR);

    als_err_bank #(.N(NE)) u_err (
        .clk(clk), .rst_any(rst_any), .evt(err_evt), .clr(err_clr), .q(err_q)
    );

    als_alm_track #(.N(NA), .RST(ARV)) u_alm (
        .clk(clk), .rst_any(rst_any), .lvl(alm_lvl), .q(alm_q), .chg(alm_chg)
    );

    als_intr_gen u_intr (
        .clk(clk), .rst_any(rst_any), .set((|err_evt) | alm_chg),
        .rd(req.en), .intr(intr)
    );

    als_rd_port #(.NE(NE), .NA(NA), .DW(DW)) u_rd (
        .clk(clk), .rst_any(rst_any), .req(req), .err_q(err_q),
        .alm_q(alm_q), .rd_data(rd_data)
    );
endmodule

// File: rtl/als_status_chk.sv
module als_status_chk #(
    parameter int NE = 9,
    parameter int NA = 4,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          sw_rst,
    input logic [NE-1:0] err_evt,
    input logic [NA-1:0] alm_lvl,
    input logic          rd_en,
    input logic          rd_sel,
    input logic [DW-1:0] rd_data,
    input logic          intr,
    input logic [NE-1:0] err_q,
    input logic [NA-1:0] alm_q
);
    p_set_r1: assert property (@(posedge clk) disable iff (rst || sw_rst)
        (|err_evt) |=> intr);

    p_hold_r2: assert property (@(posedge clk) disable iff (rst || sw_rst)
        !(rd_en && !rd_sel) |=> ((err_q & $past(err_q)) == $past(err_q)));

    p_clr_r3: assert property (@(posedge clk) disable iff (rst || sw_rst)
        (rd_en && !rd_sel) |=> (rd_data[NE-1:0] == $past(err_q)) && (err_q == $past(err_evt)));

    p_track_r5: assert property (@(posedge clk) disable iff (rst || sw_rst)
        1'b1 |=> (alm_q == $past(alm_lvl)));

    p_edge_r6: assert property (@(posedge clk) disable iff (rst || sw_rst)
        (alm_lvl != alm_q) |=> intr);

    p_drop_r7: assert property (@(posedge clk) disable iff (rst || sw_rst)
        (rd_en && !(|err_evt) && (alm_lvl == alm_q)) |=> !intr);

    p_keep_r10: assert property (@(posedge clk) disable iff (rst || sw_rst)
        (!rd_en && intr) |=> intr);
endmodule

bind als_status_top als_status_chk #(.NE(NE), .NA(NA), .DW(DW)) u_chk (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .err_evt(err_evt), .alm_lvl(alm_lvl),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .intr(intr),
    .err_q(err_q), .alm_q(alm_q)
);

// File: tb/tb_als_status_top.sv
module tb_als_status_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sw_rst = 1'b0;
    logic [8:0]  err_evt = '0;
    logic [3:0]  alm_lvl = 4'hD;
    logic        rd_en = 1'b0;
    logic        rd_sel = 1'b0;
    logic [15:0] rd_data;
    logic        intr;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    als_status_top dut (
        .clk(clk), .rst(rst), .sw_rst(sw_rst), .err_evt(err_evt), .alm_lvl(alm_lvl),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .intr(intr)
    );

    // row layout: {err 9, alm 4, rd 1, sel 1, exp_intr 1, chk_data 1, exp_data 9}
    localparam int NV = 15;
    localparam logic [25:0] VEC [NV] = '{
        {9'h000, 4'hD, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000}, // 0 idle
        {9'h001, 4'hD, 1'b0, 1'b0, 1'b1, 1'b0, 9'h000}, // 1 R1 section parity
        {9'h000, 4'hD, 1'b1, 1'b1, 1'b0, 1'b1, 9'h00D}, // 2 R5 R7 alarm read
        {9'h000, 4'hD, 1'b1, 1'b0, 1'b0, 1'b1, 9'h001}, // 3 R2 R3 error read
        {9'h000, 4'hD, 1'b1, 1'b0, 1'b0, 1'b1, 9'h000}, // 4 R3 cleared
        {9'h100, 4'hD, 1'b0, 1'b0, 1'b1, 1'b0, 9'h000}, // 5 R1 path CV overflow
        {9'h010, 4'hD, 1'b1, 1'b0, 1'b1, 1'b1, 9'h100}, // 6 R4 event during read
        {9'h000, 4'hD, 1'b1, 1'b0, 1'b0, 1'b1, 9'h010}, // 7 R4 event kept
        {9'h000, 4'hC, 1'b0, 1'b0, 1'b1, 1'b0, 9'h000}, // 8 R6 falling alarm
        {9'h000, 4'hC, 1'b0, 1'b0, 1'b1, 1'b0, 9'h000}, // 9 R10 hold
        {9'h000, 4'hE, 1'b1, 1'b1, 1'b1, 1'b1, 9'h00C}, // 10 R8 R6 rise during read
        {9'h000, 4'hE, 1'b1, 1'b1, 1'b0, 1'b1, 9'h00E}, // 11 R5 R7
        {9'h1FF, 4'hE, 1'b0, 1'b0, 1'b1, 1'b0, 9'h000}, // 12 R1 all errors
        {9'h000, 4'hE, 1'b1, 1'b1, 1'b0, 1'b1, 9'h00E}, // 13 R2 alarm read keeps errors
        {9'h000, 4'hE, 1'b1, 1'b0, 1'b0, 1'b1, 9'h1FF}  // 14 R2 R3
    };

    function automatic string req_of(input int i);
        case (i)
            1, 5, 12:    return "R1";
            13:          return "R2";
            3, 4, 14:    return "R3";
            6, 7:        return "R4";
            2, 11:       return "R5";
            8:           return "R6";
            10:          return "R8";
            9:           return "R10";
            default:     return "R7";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic [8:0] e, input logic [3:0] a,
                        input logic r, input logic s);
        @(negedge clk);
        err_evt = e; alm_lvl = a; rd_en = r; rd_sel = s;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #4000000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R9 hardware reset state
        check("R9", "intr after rst", {15'b0, intr}, 16'h0000);
        check("R9", "rd_data after rst", rd_data, 16'h0000);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][25:17], VEC[i][16:13], VEC[i][12], VEC[i][11]);
            check(req_of(i), $sformatf("intr row %0d", i), {15'b0, intr}, {15'b0, VEC[i][10]});
            if (VEC[i][9])
                check(req_of(i), $sformatf("rd_data row %0d", i), rd_data, {7'b0, VEC[i][8:0]});
        end

        // R9 software reset: set errors and move the alarms, then reset
        step(9'h0A5, 4'h2, 1'b0, 1'b0);
        check("R1", "intr before sw_rst", {15'b0, intr}, 16'h0001);
        @(negedge clk);
        sw_rst = 1'b1; err_evt = '0; alm_lvl = 4'hD;
        @(posedge clk);
        #1;
        @(negedge clk);
        sw_rst = 1'b0;
        check("R9", "intr after sw_rst", {15'b0, intr}, 16'h0000);
        check("R9", "rd_data after sw_rst", rd_data, 16'h0000);
        step(9'h000, 4'hD, 1'b1, 1'b1);
        check("R9", "alarm word after sw_rst", rd_data, 16'h000D);
        step(9'h000, 4'hD, 1'b1, 1'b0);
        check("R9", "error word after sw_rst", rd_data, 16'h0000);
        check("R9", "intr quiet after sw_rst", {15'b0, intr}, 16'h0000);

        // R2 error held across idle cycles
        step(9'h040, 4'hD, 1'b0, 1'b0);
        step(9'h000, 4'hD, 1'b0, 1'b0);
        step(9'h000, 4'hD, 1'b0, 1'b0);
        check("R10", "intr held idle", {15'b0, intr}, 16'h0001);
        step(9'h000, 4'hD, 1'b1, 1'b0);
        check("R2", "error held idle", rd_data, 16'h0040);

        // R6 rising alarm alone, then read with no change drops intr
        step(9'h000, 4'hF, 1'b0, 1'b0);
        check("R6", "intr on rise", {15'b0, intr}, 16'h0001);
        step(9'h000, 4'hF, 1'b1, 1'b1);
        check("R7", "intr after read", {15'b0, intr}, 16'h0000);
        check("R5", "alarm word", rd_data, 16'h000F);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule